// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a two-wire serial slave that holds eight 8-bit control registers and exposes their contents as a flat output vector for the logic around it. A host reaches the registers through four kinds of transfer: single-register write, single-register read, multi-register write and multi-register read. The byte that follows the slave address is a command. Its top bit chooses between single-register and multi-register access. For single-register access, its lower seven bits give the register offset.

Multi-register transfers always begin at register 0 and walk upward, one register per byte. A multi-register write carries a count byte ahead of its data. A multi-register read returns a count byte first. Register 6 carries three read-only strap bits in its low positions, and register 7 is a read-only identification byte. Both are taken from input ports.

The serial lines are oversampled by the system clock. SDA leaves the block as an open-drain enable. The block does not stretch the clock, does not check packet errors and has no bus timeouts.

Top module: `smbreg_slave`

## Requirements
- R1: After reset the registers hold the following values, with register n at ctrlRegs[8n+7:8n]:
  - register 0 = FFh, register 1 = FEh, register 2 = FFh, register 3 = 00h, register 4 = 07h, register 5 = 00h;
  - register 6 = 00111b in bits 7:3, with bits 2:0 equal to strapBits;
  - register 7 = idByte.
- R2: The slave responds only to the 7-bit address 69h (D2h to write, D3h to read). Any other address is not acknowledged, and the bytes that follow it are ignored until the next start.
- R3: A command byte with bit 7 = 1 selects single-register access at the offset in bits 6:0. In a write, the address, command and data bytes are each acknowledged, and the data byte is stored at that offset.
- R4: In a single-register read, the command is followed by a repeated start and the read address. The slave then returns the register at the commanded offset, most significant bit first.
- R5: A command byte with bit 7 = 0 selects a multi-register write. The next byte is a count, which is acknowledged and otherwise unused. Each following data byte goes to offsets 0, 1, 2 and so on. A stop after any complete byte leaves the later registers untouched. At most one register changes per clock.
- R6: A multi-register read first returns a count byte of 08h, then the registers from offset 0 upward.
- R7: After the host answers a read byte with a not-acknowledge, the slave releases SDA and drives nothing until the next start.
- R8: The following writes are acknowledged but have no effect: writes to register 6 bits 2:0, writes to register 7, and writes to offsets 8 and above.
- R9: A read at offset 8 or above returns 00h, including bytes read past the last register in a multi-register read.
- R10: A stop or repeated start inside a byte ends the transfer without changing any register. Registers change only while SCL is low.
- R11: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock from the bus |
| sdaIn | input | 1 | Serial data as seen on the bus |
| sdaOe | output | 1 | When 1, the bus data line is pulled low |
| strapBits | input | STRAP_W (3) | Read-only value shown in register 6 bits 2:0 |
| idByte | input | 8 | Read-only value shown as register 7 |
| ctrlRegs | output | NUM_REGS*8 (64) | All register contents, register n at bits 8n+7:8n |

## Verification
SCL and SDA pass through two synchronizer flops and one edge register, so the block acts on the third clock after a line edge. A received byte is stored about three clocks after the SCL fall that ends its eighth bit, and the acknowledge or the next read bit is driven after the same delay. The bench holds each SCL level for ten clocks, and it checks the acknowledge and read data at the middle of the SCL high phase. It compares its register model with ctrlRegs on every clock in which SCL is high, which avoids the short window after a SCL fall while a write is still landing.

// File: rtl/smbreg_pkg.sv
package smbreg_pkg;

  // Control-to-datapath strobes
  typedef struct packed {
    logic       wrEn;
    logic [6:0] wrAddr;
    logic [7:0] wrData;
    logic [6:0] rdAddr;
  } regStrobe_t;

  // Power-up contents of the writable registers
  function automatic logic [7:0] resetValue(input int idx);
    case (idx)
      0:       return 8'hFF;
      1:       return 8'hFE;
      2:       return 8'hFF;
      4:       return 8'h07;
      6:       return 8'h38;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smbreg_ctrl.sv
module smbreg_ctrl
  import smbreg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter logic [7:0] BLOCK_COUNT = 8'd8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdData,
  output logic       sdaOe,
  output regStrobe_t strobe
);

  typedef enum logic [2:0] {PH_IDLE, PH_ADDR, PH_CMD, PH_COUNT, PH_WDATA, PH_RDATA} phase_t;

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  phase_t     phase, nextPhase;
  logic [3:0] bitCnt;
  logic [7:0] shiftReg;
  logic       blockMode, sendCount, masterNack;
  logic [6:0] ptr;
  logic       wrEnQ;
  logic [6:0] wrAddrQ;
  logic [7:0] wrDataQ;

  wire sclNow    = sclSync[1];
  wire sdaNow    = sdaSync[1];
  wire sclRise   = sclNow & ~sclPrev;
  wire sclFall   = ~sclNow & sclPrev;
  wire startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
  wire stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      nextPhase  <= PH_IDLE;
      bitCnt     <= '0;
      shiftReg   <= '0;
      blockMode  <= 1'b0;
      sendCount  <= 1'b0;
      masterNack <= 1'b0;
      ptr        <= '0;
      sdaOe      <= 1'b0;
      wrEnQ      <= 1'b0;
      wrAddrQ    <= '0;
      wrDataQ    <= '0;
    end else begin
      wrEnQ <= 1'b0;
      if (startSeen) begin
        phase  <= PH_ADDR;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
      end else if (stopSeen) begin
        phase  <= PH_IDLE;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (sclRise) begin
          if (bitCnt < 4'd8) begin
            if (phase != PH_RDATA) shiftReg <= {shiftReg[6:0], sdaNow};
            bitCnt <= bitCnt + 4'd1;
          end else if (bitCnt == 4'd8) begin
            if (phase == PH_RDATA) masterNack <= sdaNow;
            bitCnt <= 4'd9;
          end
        end else if (sclFall) begin
          if (bitCnt == 4'd8) begin
            sdaOe <= 1'b0;
            case (phase)
              PH_ADDR: begin
                if (shiftReg[7:1] == DEV_ADDR) begin
                  sdaOe <= 1'b1;
                  if (shiftReg[0]) begin
                    nextPhase <= PH_RDATA;
                    if (blockMode) begin
                      sendCount <= 1'b1;
                      ptr       <= '0;
                    end
                  end else begin
                    nextPhase <= PH_CMD;
                  end
                end else begin
                  nextPhase <= PH_IDLE;
                end
              end
              PH_CMD: begin
                sdaOe     <= 1'b1;
                blockMode <= ~shiftReg[7];
                ptr       <= shiftReg[7] ? shiftReg[6:0] : 7'd0;
                nextPhase <= shiftReg[7] ? PH_WDATA : PH_COUNT;
              end
              PH_COUNT: begin
                sdaOe     <= 1'b1;
                nextPhase <= PH_WDATA;
              end
              PH_WDATA: begin
                sdaOe   <= 1'b1;
                wrEnQ   <= 1'b1;
                wrAddrQ <= ptr;
                wrDataQ <= shiftReg;
                if (ptr != '1) ptr <= ptr + 7'd1;
                nextPhase <= PH_WDATA;
              end
              PH_RDATA: nextPhase <= PH_RDATA;
              default:  nextPhase <= PH_IDLE;
            endcase
          end else if (bitCnt == 4'd9) begin
            bitCnt <= '0;
            sdaOe  <= 1'b0;
            if (phase == PH_RDATA && masterNack) begin
              phase <= PH_IDLE;
            end else begin
              phase <= nextPhase;
              if (nextPhase == PH_RDATA) begin
                if (sendCount) begin
                  shiftReg  <= BLOCK_COUNT;
                  sendCount <= 1'b0;
                  sdaOe     <= ~BLOCK_COUNT[7];
                end else begin
                  shiftReg <= rdData;
                  sdaOe    <= ~rdData[7];
                  if (ptr != '1) ptr <= ptr + 7'd1;
                end
              end
            end
          end else if (phase == PH_RDATA) begin
            shiftReg <= {shiftReg[6:0], 1'b0};
            sdaOe    <= ~shiftReg[6];
          end
        end
      end
    end
  end

  assign strobe = '{wrEn: wrEnQ, wrAddr: wrAddrQ, wrData: wrDataQ, rdAddr: ptr};

endmodule

// File: rtl/smbreg_regs.sv
module smbreg_regs
  import smbreg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int STRAP_W  = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobe_t            strobe,
  input  logic [STRAP_W-1:0]    strapBits,
  input  logic [7:0]            idByte,
  output logic [7:0]            rdData,
  output logic [NUM_REGS*8-1:0] regsFlat
);

  localparam int STATUS_IDX = NUM_REGS - 2;
  localparam int ID_IDX     = NUM_REGS - 1;
  localparam int IDX_W      = $clog2(NUM_REGS);

  logic [7:0] store [NUM_REGS-1];
  logic [7:0] view  [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS - 1; i++) begin : g_reg
    wire hit = strobe.wrEn && (strobe.wrAddr == 7'(i));
    if (i == STATUS_IDX) begin : g_status
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)    store[i] <= {resetValue(i)[7:STRAP_W], {STRAP_W{1'b0}}};
        else if (hit) store[i] <= {strobe.wrData[7:STRAP_W], {STRAP_W{1'b0}}};
      end
      assign view[i] = {store[i][7:STRAP_W], strapBits};
    end else begin : g_plain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)    store[i] <= resetValue(i);
        else if (hit) store[i] <= strobe.wrData;
      end
      assign view[i] = store[i];
    end
  end

  assign view[ID_IDX] = idByte;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_flat
    assign regsFlat[i*8 +: 8] = view[i];
  end

  assign rdData = (strobe.rdAddr < 7'(NUM_REGS)) ? view[strobe.rdAddr[IDX_W-1:0]] : 8'h00;

endmodule

// File: rtl/smbreg_slave.sv
module smbreg_slave
  import smbreg_pkg::*;
#(
  parameter int         NUM_REGS = 8,
  parameter int         STRAP_W  = 3,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  input  logic [STRAP_W-1:0]    strapBits,
  input  logic [7:0]            idByte,
  output logic [NUM_REGS*8-1:0] ctrlRegs
);

  localparam logic [7:0] BLOCK_COUNT = 8'(NUM_REGS);

  regStrobe_t strobe;
  logic [7:0] rdData;

  smbreg_ctrl #(
    .DEV_ADDR   (DEV_ADDR),
    .BLOCK_COUNT(BLOCK_COUNT)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (sclIn),
    .sdaIn (sdaIn),
    .rdData(rdData),
    .sdaOe (sdaOe),
    .strobe(strobe)
  );

  smbreg_regs #(
    .NUM_REGS(NUM_REGS),
    .STRAP_W (STRAP_W)
  ) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .strapBits(strapBits),
    .idByte   (idByte),
    .rdData   (rdData),
    .regsFlat (ctrlRegs)
  );

endmodule

// File: rtl/smbreg_chk.sv
module smbreg_chk #(
  parameter int NUM_REGS = 8,
  parameter int STRAP_W  = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclIn,
  input logic                  sdaOe,
  input logic [NUM_REGS*8-1:0] ctrlRegs
);

  localparam int RW_REGS = NUM_REGS - 2;
  localparam int RW_BITS = RW_REGS * 8;

  function automatic logic [RW_BITS-1:0] defaultsLow();
    logic [RW_BITS-1:0] v;
    v = '0;
    for (int i = 0; i < RW_REGS; i++) v[i*8 +: 8] = smbreg_pkg::resetValue(i);
    return v;
  endfunction

  localparam logic [RW_BITS-1:0] DEFAULTS = defaultsLow();

  logic [RW_BITS-1:0] prevRegs;
  logic               prevValid;
  logic [RW_REGS-1:0] changedRegs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevValid <= 1'b0;
      prevRegs  <= '0;
    end else begin
      prevValid <= 1'b1;
      prevRegs  <= ctrlRegs[RW_BITS-1:0];
    end
  end

  always_comb begin
    for (int i = 0; i < RW_REGS; i++)
      changedRegs[i] = (prevRegs[i*8 +: 8] != ctrlRegs[i*8 +: 8]);
  end

  // R1
  reset_default_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (ctrlRegs[RW_BITS-1:0] == DEFAULTS));

  // R5
  single_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    prevValid |-> $onehot0(changedRegs));

  // R10
  update_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctrlRegs[RW_BITS-1:0]) |-> !sclIn);

  // R11
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn)) |-> $stable(sdaOe));

endmodule

bind smbreg_slave smbreg_chk #(
  .NUM_REGS(NUM_REGS),
  .STRAP_W (STRAP_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .sclIn   (sclIn),
  .sdaOe   (sdaOe),
  .ctrlRegs(ctrlRegs)
);

// File: tb/test_smbreg_slave.sv
`timescale 1ns/1ps
module test_smbreg_slave;

  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] IDVAL = 8'h18;

  logic        clk = 1'b0;
  logic        rstN;
  logic        sclLine, sdaDrv;
  logic        sdaOe;
  logic [63:0] ctrlRegs;
  wire         sdaLine = sdaDrv & ~sdaOe;

  int    compared = 0;
  int    mismatched = 0;
  bit    compareOn = 1'b0;
  bit    done = 1'b0;
  string curReq = "R1";
  logic [7:0] model [8];

  always #10 clk = ~clk;

  smbreg_slave i_smbreg_slave (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclLine),
    .sdaIn    (sdaLine),
    .sdaOe    (sdaOe),
    .strapBits(STRAP),
    .idByte   (IDVAL),
    .ctrlRegs (ctrlRegs)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Register model compared on every clock while SCL is high
  always @(negedge clk) begin
    if (compareOn && rstN && sclLine) begin
      compared++;
      for (int i = 0; i < 8; i++) begin
        if (ctrlRegs[i*8 +: 8] !== model[i]) begin
          mismatched++;
          $display("FAIL %s: reg%0d actual %0h expected %0h", curReq, i, ctrlRegs[i*8 +: 8], model[i]);
        end
      end
    end
  end

  function automatic void applyWrite(input int idx, input logic [7:0] d);
    if (idx < 6) model[idx] = d;
    else if (idx == 6) model[6] = {d[7:3], STRAP};
  endfunction

  task automatic sendBit(input logic b);
    sclLine = 1'b0; tick(3); sdaDrv = b; tick(7); sclLine = 1'b1; tick(10);
  endtask

  task automatic sendByte(input logic [7:0] b, input int wrIdx, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sclLine = 1'b0;
    if (wrIdx >= 0) applyWrite(wrIdx, b);
    tick(2); sdaDrv = 1'b1; tick(8); sclLine = 1'b1; tick(5); ack = ~sdaLine; tick(5);
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] v);
    v = '0;
    for (int i = 0; i < 8; i++) begin
      sclLine = 1'b0; tick(2); sdaDrv = 1'b1; tick(8); sclLine = 1'b1; tick(5);
      v = {v[6:0], sdaLine}; tick(5);
    end
    sendBit(nack);
  endtask

  task automatic startCond();
    sclLine = 1'b0; tick(4); sdaDrv = 1'b1; tick(6); sclLine = 1'b1; tick(10); sdaDrv = 1'b0; tick(10);
  endtask

  task automatic stopCond();
    sclLine = 1'b0; tick(4); sdaDrv = 1'b0; tick(6); sclLine = 1'b1; tick(10); sdaDrv = 1'b1; tick(10);
  endtask

  task automatic writeOne(input string req, input logic [6:0] off, input logic [7:0] d);
    logic ack;
    startCond();
    sendByte(8'hD2, -1, ack);          check(req, ack, 1);
    sendByte({1'b1, off}, -1, ack);    check(req, ack, 1);
    sendByte(d, int'(off), ack);       check(req, ack, 1);
    stopCond();
  endtask

  task automatic readOne(input string req, input logic [6:0] off, input int exp);
    logic ack;
    logic [7:0] v;
    startCond();
    sendByte(8'hD2, -1, ack);          check(req, ack, 1);
    sendByte({1'b1, off}, -1, ack);    check(req, ack, 1);
    startCond();
    sendByte(8'hD3, -1, ack);          check(req, ack, 1);
    recvByte(1'b1, v);                 check(req, v, exp);
    stopCond();
  endtask

  initial begin
    logic ack;
    logic [7:0] v;
    model[0] = 8'hFF; model[1] = 8'hFE; model[2] = 8'hFF; model[3] = 8'h00;
    model[4] = 8'h07; model[5] = 8'h00; model[6] = {5'b00111, STRAP}; model[7] = IDVAL;
    rstN = 1'b0; sclLine = 1'b1; sdaDrv = 1'b1;
    tick(5);
    rstN = 1'b1;
    tick(2);
    // R1 reset values
    for (int i = 0; i < 8; i++) check("R1", ctrlRegs[i*8 +: 8], model[i]);
    check("R1", sdaOe, 0);
    compareOn = 1'b1;

    // R3 single write, R4 single read
    curReq = "R3";
    writeOne("R3", 7'd2, 8'h5A);
    curReq = "R4";
    readOne("R4", 7'd2, 8'h5A);
    readOne("R4", 7'd4, 8'h07);

    // R8 read-only bits and out-of-range offsets
    curReq = "R8";
    writeOne("R8", 7'd6, 8'hFF);
    writeOne("R8", 7'd7, 8'h00);
    writeOne("R8", 7'h10, 8'h33);
    readOne("R8", 7'd6, {5'b11111, STRAP});
    readOne("R8", 7'd7, IDVAL);

    // R9 read past last register
    curReq = "R9";
    readOne("R9", 7'h20, 8'h00);

    // R2 foreign addresses
    curReq = "R2";
    startCond();
    sendByte(8'hA0, -1, ack);  check("R2", ack, 0);
    sendByte(8'h81, -1, ack);  check("R2", ack, 0);
    sendByte(8'h00, -1, ack);  check("R2", ack, 0);
    stopCond();
    startCond();
    sendByte(8'hD4, -1, ack);  check("R2", ack, 0);
    stopCond();

    // R5 block write, stop after third data byte
    curReq = "R5";
    startCond();
    sendByte(8'hD2, -1, ack);  check("R5", ack, 1);
    sendByte(8'h00, -1, ack);  check("R5", ack, 1);
    sendByte(8'h03, -1, ack);  check("R5", ack, 1);
    sendByte(8'h11, 0, ack);   check("R5", ack, 1);
    sendByte(8'h22, 1, ack);   check("R5", ack, 1);
    sendByte(8'h33, 2, ack);   check("R5", ack, 1);
    stopCond();
    check("R5", ctrlRegs[31:24], 8'h00);

    // R6 block read of all registers, R7 release after NACK
    curReq = "R6";
    startCond();
    sendByte(8'hD2, -1, ack);  check("R6", ack, 1);
    sendByte(8'h00, -1, ack);  check("R6", ack, 1);
    startCond();
    sendByte(8'hD3, -1, ack);  check("R6", ack, 1);
    recvByte(1'b0, v);         check("R6", v, 8'h08);
    for (int i = 0; i < 8; i++) begin
      recvByte(i == 7, v);     check("R6", v, model[i]);
    end
    curReq = "R7";
    for (int i = 0; i < 9; i++) begin
      sclLine = 1'b0; tick(2); sdaDrv = 1'b1; tick(8); sclLine = 1'b1; tick(5);
      check("R7", sdaLine, 1); tick(5);
    end
    stopCond();

    // R9 block read running past the last register
    curReq = "R9";
    startCond();
    sendByte(8'hD2, -1, ack);  check("R9", ack, 1);
    sendByte(8'h00, -1, ack);  check("R9", ack, 1);
    startCond();
    sendByte(8'hD3, -1, ack);  check("R9", ack, 1);
    recvByte(1'b0, v);         check("R9", v, 8'h08);
    for (int i = 0; i < 8; i++) recvByte(1'b0, v);
    recvByte(1'b1, v);         check("R9", v, 8'h00);
    stopCond();

    // R10 stop inside a data byte
    curReq = "R10";
    startCond();
    sendByte(8'hD2, -1, ack);  check("R10", ack, 1);
    sendByte(8'h83, -1, ack);  check("R10", ack, 1);
    for (int i = 7; i >= 4; i--) sendBit(i[0]);
    stopCond();
    readOne("R10", 7'd3, 8'h00);
    // R10 repeated start inside a data byte, then read the same offset
    startCond();
    sendByte(8'hD2, -1, ack);  check("R10", ack, 1);
    sendByte(8'h84, -1, ack);  check("R10", ack, 1);
    for (int i = 0; i < 5; i++) sendBit(1'b0);
    startCond();
    sendByte(8'hD3, -1, ack);  check("R10", ack, 1);
    recvByte(1'b1, v);         check("R10", v, 8'h07);
    stopCond();

    tick(20);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule